// File: doc/BRIEF.md
# Next Program Counter Selector

This block chooses the address of the next instruction for a 32-bit core whose instructions are all four bytes long. Each cycle it takes the current instruction address, the primary operation code, the secondary register field (which also serves as a sub-selector for one opcode), the 16-bit branch displacement, the 26-bit jump index and the two register operand values. It then registers three results: the next address, a flag that says control flow left the sequential path, and a flag for an undefined sub-selector.

The block handles three cases. Two branches compare the operands for equality or inequality. Four branches test the first operand against zero as a signed number. The unconditional jump builds its target by splicing bits together, with no addition. Anything else falls through to the sequential address. Results appear one clock after the inputs are sampled.

Top module: `npc_unit`

## Requirements
- R1: While reset is low, and at once when it falls, `next_pc_o`, `taken_o` and `illegal_o` are all zero.
- R2: Outputs are registered. Inputs sampled at a rising edge show on the outputs after that edge, and they hold until the following edge.
- R3: Any opcode other than 1, 2, 4, 5, 6 or 7 gives `next_pc_o` = PC+4 with `taken_o`=0 and `illegal_o`=0.
- R4: Opcode 4 is taken when `rs_i` equals `rt_i`. Opcode 5 is taken when they differ.
- R5: Opcode 6 is taken when `rs_i` is less than or equal to zero, as a signed value. Opcode 7 is taken when `rs_i` is greater than zero, as a signed value.
- R6: Opcode 1 with `rt_sel_i`=0 is taken when `rs_i` is negative. Opcode 1 with `rt_sel_i`=1 is taken when `rs_i` is zero or positive.
- R7: Opcode 1 with any other `rt_sel_i` value is not taken: it gives PC+4 and `illegal_o`=1.
- R8: A taken branch gives PC+4 plus the sign-extended displacement times four, wrapping modulo 2^32. A branch that is not taken gives PC+4.
- R9: Opcode 2 is always taken. Its target is bits 31:28 of PC+4, then the 26-bit index, then two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current instruction address |
| opcode_i | input | 6 | Primary operation code |
| rt_sel_i | input | 5 | Secondary register field, used as sub-selector for opcode 1 |
| offset_i | input | 16 | Signed branch displacement in words |
| jidx_i | input | 26 | Jump word index |
| rs_i | input | 32 | First register operand value |
| rt_i | input | 32 | Second register operand value |
| next_pc_o | output | 32 | Registered next instruction address |
| taken_o | output | 1 | Registered taken flag |
| illegal_o | output | 1 | Registered undefined sub-selector flag |

## Verification
The sequential increment and the target calculation work in the same cycle. Both the jump splice and the branch adder take PC+4 as their base. The bench drives addresses where PC+4 carries into the top nibble, for example a jump from 0x0FFFFFFC. There the jump must pick up the incremented upper bits, not the current ones. It also drives branches whose target wraps past address zero in either direction. Each result is compared with a target worked out by hand in the vector table.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [5:0] {
    OP_REGIMM = 6'd1,
    OP_JUMP   = 6'd2,
    OP_EQ     = 6'd4,
    OP_NE     = 6'd5,
    OP_LEZ    = 6'd6,
    OP_GTZ    = 6'd7
  } npc_op_e;

  typedef enum logic [3:0] {
    K_SEQ, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ, K_JMP, K_BAD
  } npc_kind_e;

  // Sign-extend a displacement and scale it by four (word to byte).
  function automatic logic [31:0] disp_bytes(input logic [15:0] d);
    logic [31:0] ext;
    ext = {{16{d[15]}}, d};
    return {ext[29:0], 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int OPW = 6,
  parameter int RSW = 5
) (
  input  logic [OPW-1:0] opcode,
  input  logic [RSW-1:0] rt_sel,
  output npc_kind_e      kind
);
  always_comb begin
    unique case (opcode)
      OPW'(OP_EQ):    kind = K_EQ;
      OPW'(OP_NE):    kind = K_NE;
      OPW'(OP_LEZ):   kind = K_LEZ;
      OPW'(OP_GTZ):   kind = K_GTZ;
      OPW'(OP_JUMP):  kind = K_JMP;
      OPW'(OP_REGIMM): begin
        if (rt_sel == RSW'(0))      kind = K_LTZ;
        else if (rt_sel == RSW'(1)) kind = K_GEZ;
        else                        kind = K_BAD;
      end
      default:        kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  npc_kind_e       kind,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            cond_met
);
  logic is_neg, is_zero, is_same;

  assign is_neg  = rs_val[XLEN-1];
  assign is_zero = (rs_val == '0);
  assign is_same = (rs_val == rt_val);

  always_comb begin
    unique case (kind)
      K_EQ:    cond_met = is_same;
      K_NE:    cond_met = !is_same;
      K_LEZ:   cond_met = is_neg || is_zero;
      K_GTZ:   cond_met = !is_neg && !is_zero;
      K_LTZ:   cond_met = is_neg;
      K_GEZ:   cond_met = !is_neg;
      K_JMP:   cond_met = 1'b1;
      default: cond_met = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int JW   = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [OFFW-1:0] offset,
  input  logic [JW-1:0]   jidx,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);
  localparam int HI_W = XLEN - JW - 2;

  assign seq_pc = pc + XLEN'(4);
  assign br_pc  = seq_pc + disp_bytes(offset);
  assign jmp_pc = {seq_pc[XLEN-1 -: HI_W], jidx, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OPW  = 6,
  parameter int RSW  = 5,
  parameter int OFFW = 16,
  parameter int JW   = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic [OPW-1:0]  opcode_i,
  input  logic [RSW-1:0]  rt_sel_i,
  input  logic [OFFW-1:0] offset_i,
  input  logic [JW-1:0]   jidx_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            illegal_o
);
  npc_kind_e       kind;
  logic            cond_met;
  logic            is_jump, bad_sel;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, pc_d;
  logic            primed;

  npc_decode #(.OPW(OPW), .RSW(RSW)) u_dec (
    .opcode(opcode_i), .rt_sel(rt_sel_i), .kind(kind)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind(kind), .rs_val(rs_i), .rt_val(rt_i), .cond_met(cond_met)
  );

  npc_target #(.XLEN(XLEN), .OFFW(OFFW), .JW(JW)) u_tgt (
    .pc(pc_i), .offset(offset_i), .jidx(jidx_i),
    .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
  );

  assign is_jump = (kind == K_JMP);
  assign bad_sel = (kind == K_BAD);

  always_comb begin
    if (is_jump)       pc_d = jmp_pc;
    else if (cond_met) pc_d = br_pc;
    else               pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
      primed    <= 1'b0;
    end else begin
      next_pc_o <= pc_d;
      taken_o   <= cond_met;
      illegal_o <= bad_sel;
      primed    <= 1'b1;
    end
  end

  assert_illegal_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !taken_o);

  assert_seq_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !taken_o |-> next_pc_o == $past(pc_i) + XLEN'(4));

  assert_jump_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(opcode_i) == OPW'(2) |-> taken_o && !illegal_o);

  assert_aligned_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(pc_i[1:0]) == 2'b00 |-> next_pc_o[1:0] == 2'b00);

  assert_equal_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(opcode_i) == OPW'(4) && $past(rs_i == rt_i) |-> taken_o);
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  typedef struct packed {
    logic [31:0] pc;
    logic [5:0]  op;
    logic [4:0]  rf;
    logic [15:0] off;
    logic [25:0] ji;
    logic [31:0] rs;
    logic [31:0] rv;
    logic [31:0] npc;
    logic        tk;
    logic        il;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{32'h00400000, 6'd0, 5'd0, 16'h0000, 26'h0, 32'd1, 32'd1, 32'h00400004, 1'b0, 1'b0, 8'd3}, // R3 register op
    '{32'h00400000, 6'd4, 5'd0, 16'h0003, 26'h0, 32'd5, 32'd5, 32'h00400010, 1'b1, 1'b0, 8'd4}, // R4 eq taken
    '{32'h00400000, 6'd4, 5'd0, 16'h0003, 26'h0, 32'd5, 32'd6, 32'h00400004, 1'b0, 1'b0, 8'd4}, // R4 eq not
    '{32'h00400000, 6'd5, 5'd0, 16'hFFFF, 26'h0, 32'd5, 32'd6, 32'h00400000, 1'b1, 1'b0, 8'd4}, // R4 ne back
    '{32'h00400000, 6'd5, 5'd0, 16'hFFFF, 26'h0, 32'd7, 32'd7, 32'h00400004, 1'b0, 1'b0, 8'd4}, // R4 ne not
    '{32'h00001000, 6'd6, 5'd0, 16'h0010, 26'h0, 32'd0, 32'd9, 32'h00001044, 1'b1, 1'b0, 8'd5}, // R5 lez zero
    '{32'h00002000, 6'd6, 5'd0, 16'h0002, 26'h0, 32'h80000000, 32'd0, 32'h0000200C, 1'b1, 1'b0, 8'd5}, // R5 lez neg
    '{32'h00002000, 6'd6, 5'd0, 16'h0002, 26'h0, 32'd1, 32'd0, 32'h00002004, 1'b0, 1'b0, 8'd5}, // R5 lez pos
    '{32'h00003000, 6'd7, 5'd0, 16'h0001, 26'h0, 32'd1, 32'd0, 32'h00003008, 1'b1, 1'b0, 8'd5}, // R5 gtz pos
    '{32'h00003000, 6'd7, 5'd0, 16'h0001, 26'h0, 32'hFFFFFFFF, 32'd0, 32'h00003004, 1'b0, 1'b0, 8'd5}, // R5 gtz neg
    '{32'h00003000, 6'd7, 5'd0, 16'h0001, 26'h0, 32'd0, 32'd0, 32'h00003004, 1'b0, 1'b0, 8'd5}, // R5 gtz zero
    '{32'h00004000, 6'd1, 5'd0, 16'h0004, 26'h0, 32'hFFFFFFFF, 32'd0, 32'h00004014, 1'b1, 1'b0, 8'd6}, // R6 ltz
    '{32'h00004000, 6'd1, 5'd0, 16'h0004, 26'h0, 32'd0, 32'd0, 32'h00004004, 1'b0, 1'b0, 8'd6}, // R6 ltz zero
    '{32'h00004000, 6'd1, 5'd1, 16'h0004, 26'h0, 32'd0, 32'd0, 32'h00004014, 1'b1, 1'b0, 8'd6}, // R6 gez zero
    '{32'h00004000, 6'd1, 5'd1, 16'h0004, 26'h0, 32'h80000000, 32'd0, 32'h00004004, 1'b0, 1'b0, 8'd6}, // R6 gez neg
    '{32'h00004000, 6'd1, 5'd2, 16'h0004, 26'h0, 32'd0, 32'd0, 32'h00004004, 1'b0, 1'b1, 8'd7}, // R7 sel 2
    '{32'h00004000, 6'd1, 5'd17, 16'h0004, 26'h0, 32'hFFFFFFFF, 32'd0, 32'h00004004, 1'b0, 1'b1, 8'd7}, // R7 sel 17
    '{32'h00400000, 6'd2, 5'd0, 16'h0000, 26'h0100040, 32'd0, 32'd0, 32'h00400100, 1'b1, 1'b0, 8'd9}, // R9 plain
    '{32'h0FFFFFFC, 6'd2, 5'd0, 16'h0000, 26'h3FFFFFF, 32'd0, 32'd0, 32'h1FFFFFFC, 1'b1, 1'b0, 8'd9}, // R9 carry nibble
    '{32'hF0000000, 6'd2, 5'd0, 16'h0000, 26'h0, 32'd0, 32'd0, 32'hF0000000, 1'b1, 1'b0, 8'd9}, // R9 top nibble
    '{32'hFFFFFFF8, 6'd4, 5'd0, 16'h0001, 26'h0, 32'd3, 32'd3, 32'h00000000, 1'b1, 1'b0, 8'd8}, // R8 wrap up
    '{32'h00000000, 6'd4, 5'd0, 16'h8000, 26'h0, 32'd3, 32'd3, 32'hFFFE0004, 1'b1, 1'b0, 8'd8}, // R8 wrap down
    '{32'h00000500, 6'd8, 5'd0, 16'h0010, 26'h0, 32'd2, 32'd2, 32'h00000504, 1'b0, 1'b0, 8'd3}  // R3 other op
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [5:0]  opcode_i = '0;
  logic [4:0]  rt_sel_i = '0;
  logic [15:0] offset_i = '0;
  logic [25:0] jidx_i = '0;
  logic [31:0] rs_i = '0;
  logic [31:0] rt_i = '0;
  logic [31:0] next_pc_o;
  logic        taken_o, illegal_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .opcode_i(opcode_i),
    .rt_sel_i(rt_sel_i), .offset_i(offset_i), .jidx_i(jidx_i),
    .rs_i(rs_i), .rt_i(rt_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .illegal_o(illegal_o)
  );

  task automatic drive(input vec_t v);
    pc_i = v.pc; opcode_i = v.op; rt_sel_i = v.rf; offset_i = v.off;
    jidx_i = v.ji; rs_i = v.rs; rt_i = v.rv;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] npc,
                            input logic tk, input logic il);
    n_chk++;
    if (next_pc_o !== npc || taken_o !== tk || illegal_o !== il) begin
      n_bad++;
      $display("FAIL %s: got pc=%h tk=%b il=%b, want pc=%h tk=%b il=%b",
               tag, next_pc_o, taken_o, illegal_o, npc, tk, il);
    end
  endtask

  initial begin
    drive(VT[1]);
    @(negedge clk); @(negedge clk);
    expect_out("R1 held in reset", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      expect_out($sformatf("R%0d vector %0d", VT[i].req, i),
                 VT[i].npc, VT[i].tk, VT[i].il);
    end

    // R2: new inputs do not reach the outputs before the next rising edge
    drive(VT[1]);
    @(negedge clk);
    drive(VT[15]);
    #5;
    expect_out("R2 hold before edge", 32'h00400010, 1'b1, 1'b0);
    @(negedge clk);
    expect_out("R2 update after edge", 32'h00004004, 1'b0, 1'b1);

    // R1: asynchronous reset clears taken state immediately
    drive(VT[18]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_out("R1 async clear", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(VT[21]);
    @(negedge clk);
    expect_out("R8 after reset release", 32'hFFFE0004, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no finish, want finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule